// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block steps a program through 32-bit instruction words. It fetches one word at a time and reads the two top bits as a format code. The word then holds either one long operation or two 15-bit short operations. A short pair runs in one of two fixed orders, or as a parallel pair. For each operation the sequencer raises a one-cycle execute strobe toward outside execution units and passes along the payload and its opcode class. It then waits for a completion report that says whether the PC moved, whether an exception occurred and what the condition flag is. From that report it decides whether the second slot of the word runs.

When a word finishes, the sequencer updates the program counter: it follows a branch, steps forward one word, or applies the hardware repeat loop. It also bumps saturating event counters. An exception halts sequencing. A single-step start runs exactly one word and then reports a trap. While halted, a start pulse loads a new PC, and a repeat window can be loaded at the same time. The decoding of individual opcodes stays outside the block. An outside decoder supplies two flags that mark which short slot, if any, is a parallel-only condition test.

Top module: `issue_seq`

## Requirements
- R1: Format code `11` (word bits 31:30) issues one operation with `exe_long`=1, `exe_op` = word bits 29:0 and `exe_class` = `exe_op` bits 29:24. No second issue follows.
- R2: A short operation's payload appears zero-extended on `exe_op`, with `exe_class` = `exe_op` bits 14:9. The left slot is word bits 29:15 (`exe_left`=1) and the right slot is bits 14:0 (`exe_left`=0).
- R3: Format `01` issues left then right. Format `10` issues right then left.
- R4: In formats `01`/`10`, the second slot is dropped if the first reported a PC change or an exception. A drop caused by a PC change without an exception bumps the jump-skip counter.
- R5: In format `00` with a condition-test flag set, the flagged slot issues first (left wins if both are flagged). The other slot issues only when the returned flag is 1 and there was no exception. The flag value bumps the true counter or the false counter.
- R6: In format `00` with no test flag, left issues and then right. Right is dropped only when left raised an exception; a PC change in the left slot does not drop it.
- R7: When a word ends with repeat active and the resulting PC equal to the repeat end, the remaining count drops by one. If the count reaches zero, repeat turns off and the PC stays. Otherwise the PC is loaded with the repeat start. A load with count 0 leaves repeat off.
- R8: Otherwise the PC becomes the last reported branch target if any slot changed it, else PC+1.
- R9: Each completed word bumps the cycle counter. Each word also bumps exactly one of the long, parallel, left-first or right-first counters according to its format.
- R10: An exception in any issued slot sets `exc_seen` and halts the block. While halted there is no fetch and no issue until the next `start`.
- R11: A word run under single-step halts the block afterwards, with `trap`=1 if no exception occurred.
- R12: Counters stop at their all-ones value instead of wrapping. Reset clears them, clears the PC and leaves the block halted.
- R13: `exe_go` lasts one cycle and is never high together with `fetch_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leave halt and begin fetching at `start_pc` |
| step | input | 1 | Sampled with `start`: run one word only |
| start_pc | input | PC_W | PC loaded by `start` |
| rpt_load | input | 1 | Load repeat window while halted |
| rpt_begin | input | PC_W | Repeat loop start address |
| rpt_end | input | PC_W | Repeat loop end address |
| rpt_count | input | RPT_W | Repeat iteration count |
| fetch_req | output | 1 | Word requested at `pc` |
| insn_valid | input | 1 | Word and test flags valid |
| insn_word | input | 32 | Fetched instruction word |
| left_test | input | 1 | Left short slot is a condition test |
| right_test | input | 1 | Right short slot is a condition test |
| exe_go | output | 1 | Execute strobe, one cycle |
| exe_long | output | 1 | Issued operation is long |
| exe_left | output | 1 | Issued short operation is the left slot |
| exe_op | output | 30 | Issued payload |
| exe_class | output | 6 | Opcode class of issued operation |
| done_valid | input | 1 | Completion report valid |
| done_pc_chg | input | 1 | Operation changed the PC |
| done_pc | input | PC_W | New PC when changed |
| done_exc | input | 1 | Operation raised an exception |
| done_flag | input | 1 | Condition flag result |
| pc | output | PC_W | Program counter |
| halted | output | 1 | Sequencing stopped |
| trap | output | 1 | Stopped after a single step |
| exc_seen | output | 1 | Stopped on an exception |
| rpt_active | output | 1 | Repeat loop armed |
| cnt_cycles | output | CNT_W | Words completed |
| cnt_long | output | CNT_W | Long words |
| cnt_par | output | CNT_W | Parallel words |
| cnt_lr | output | CNT_W | Left-first words |
| cnt_rl | output | CNT_W | Right-first words |
| cnt_true | output | CNT_W | Condition tests true |
| cnt_false | output | CNT_W | Condition tests false |
| cnt_jskip | output | CNT_W | Second slots dropped by a jump |

## Verification
The bench builds the block with PC_W=8, RPT_W=4 and CNT_W=3. The narrow counters hit their all-ones value after seven words, so a run of a dozen words exercises saturation on the cycle counter. The small PC keeps branch targets and repeat windows easy to choose. A count of two drives the repeat loop through one jump back and then through the exit, where the PC stays at the end address.

// File: rtl/issue_pkg.sv
package issue_pkg;
   typedef enum logic [1:0] {
      FMT_PAR  = 2'b00,
      FMT_LR   = 2'b01,
      FMT_RL   = 2'b10,
      FMT_LONG = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      NEXT_NONE,
      NEXT_SEQ,
      NEXT_COND,
      NEXT_PAR
   } next_rule_e;

   localparam int CNT_NUM   = 8;
   localparam int CI_CYC    = 0;
   localparam int CI_LONG   = 1;
   localparam int CI_PAR    = 2;
   localparam int CI_LR     = 3;
   localparam int CI_RL     = 4;
   localparam int CI_TRUE   = 5;
   localparam int CI_FALSE  = 6;
   localparam int CI_JSKIP  = 7;
endpackage

// File: rtl/issue_decode.sv
module issue_decode
   import issue_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int OP_W    = 30,
   parameter int SHORT_W = 15
) (
   input  logic [WORD_W-1:0] word,
   input  logic              ltest,
   input  logic              rtest,
   output fmt_e              fmt,
   output next_rule_e        rule,
   output logic              first_long,
   output logic              first_left,
   output logic [OP_W-1:0]   first_op,
   output logic [OP_W-1:0]   second_op
);
   localparam int PAD_W = OP_W - SHORT_W;

   if (OP_W != WORD_W - 2) begin : g_bad_op
      $error("issue_decode: OP_W must be WORD_W-2");
   end
   if (2 * SHORT_W != OP_W) begin : g_bad_short
      $error("issue_decode: two short slots must fill OP_W");
   end

   logic [OP_W-1:0] lop, rop;
   assign lop = {{PAD_W{1'b0}}, word[OP_W-1 -: SHORT_W]};
   assign rop = {{PAD_W{1'b0}}, word[SHORT_W-1:0]};

   always_comb begin
      fmt        = fmt_e'(word[WORD_W-1 -: 2]);
      rule       = NEXT_NONE;
      first_long = 1'b0;
      first_left = 1'b1;
      first_op   = lop;
      second_op  = rop;
      case (fmt)
         FMT_LONG: begin
            first_long = 1'b1;
            first_op   = word[OP_W-1:0];
            second_op  = '0;
         end
         FMT_LR: rule = NEXT_SEQ;
         FMT_RL: begin
            rule       = NEXT_SEQ;
            first_left = 1'b0;
            first_op   = rop;
            second_op  = lop;
         end
         default: begin
            rule = (ltest || rtest) ? NEXT_COND : NEXT_PAR;
            if (!ltest && rtest) begin
               first_left = 1'b0;
               first_op   = rop;
               second_op  = lop;
            end
         end
      endcase
   end
endmodule

// File: rtl/issue_counters.sv
module issue_counters #(
   parameter int NUM = 8,
   parameter int W   = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NUM-1:0]   inc,
   output logic [NUM*W-1:0] count_flat
);
   if (W < 1) begin : g_bad_w
      $error("issue_counters: W must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_cnt
      logic [W-1:0] val;
      always_ff @(posedge clk) begin
         if (rst)
            val <= '0;
         else if (inc[i] && (val != {W{1'b1}}))
            val <= val + W'(1);
      end
      assign count_flat[i*W +: W] = val;
   end
endmodule

// File: rtl/issue_seq.sv
module issue_seq
   import issue_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int RPT_W = 16,
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              step,
   input  logic [PC_W-1:0]   start_pc,
   input  logic              rpt_load,
   input  logic [PC_W-1:0]   rpt_begin,
   input  logic [PC_W-1:0]   rpt_end,
   input  logic [RPT_W-1:0]  rpt_count,
   output logic              fetch_req,
   input  logic              insn_valid,
   input  logic [31:0]       insn_word,
   input  logic              left_test,
   input  logic              right_test,
   output logic              exe_go,
   output logic              exe_long,
   output logic              exe_left,
   output logic [29:0]       exe_op,
   output logic [5:0]        exe_class,
   input  logic              done_valid,
   input  logic              done_pc_chg,
   input  logic [PC_W-1:0]   done_pc,
   input  logic              done_exc,
   input  logic              done_flag,
   output logic [PC_W-1:0]   pc,
   output logic              halted,
   output logic              trap,
   output logic              exc_seen,
   output logic              rpt_active,
   output logic [CNT_W-1:0]  cnt_cycles,
   output logic [CNT_W-1:0]  cnt_long,
   output logic [CNT_W-1:0]  cnt_par,
   output logic [CNT_W-1:0]  cnt_lr,
   output logic [CNT_W-1:0]  cnt_rl,
   output logic [CNT_W-1:0]  cnt_true,
   output logic [CNT_W-1:0]  cnt_false,
   output logic [CNT_W-1:0]  cnt_jskip
);
   localparam int WORD_W  = 32;
   localparam int OP_W    = WORD_W - 2;
   localparam int SHORT_W = OP_W / 2;
   localparam int CLS_W   = 6;

   if (PC_W < 2 || RPT_W < 1 || CNT_W < 1) begin : g_bad_param
      $error("issue_seq: width parameters out of range");
   end

   typedef enum logic [2:0] {
      ST_HALT, ST_FETCH, ST_ISS1, ST_WAIT1, ST_ISS2, ST_WAIT2, ST_END
   } state_e;

   state_e            state;
   logic [WORD_W-1:0] word_q;
   logic              lt_q, rt_q, step_q;
   logic              r1_chg, r1_exc, r1_flag;
   logic              chg_any, exc_any;
   logic [PC_W-1:0]   tgt_q;
   logic [PC_W-1:0]   rb_q, re_q;
   logic [RPT_W-1:0]  rc_q;

   fmt_e              fmt;
   next_rule_e        rule;
   logic              first_long, first_left;
   logic [OP_W-1:0]   first_op, second_op;

   issue_decode #(.WORD_W(WORD_W), .OP_W(OP_W), .SHORT_W(SHORT_W)) u_dec (
      .word(word_q), .ltest(lt_q), .rtest(rt_q),
      .fmt(fmt), .rule(rule), .first_long(first_long), .first_left(first_left),
      .first_op(first_op), .second_op(second_op)
   );

   // Second-slot admission from the first slot's report
   logic run2;
   always_comb begin
      case (rule)
         NEXT_SEQ:  run2 = !done_pc_chg && !done_exc;
         NEXT_COND: run2 = done_flag && !done_exc;
         NEXT_PAR:  run2 = !done_exc;
         default:   run2 = 1'b0;
      endcase
   end

   // End-of-word PC resolution
   logic [PC_W-1:0] pc_now, pc_next;
   logic            rpt_hit, rpt_last;
   assign pc_now   = chg_any ? tgt_q : pc;
   assign rpt_hit  = rpt_active && (pc_now == re_q);
   assign rpt_last = (rc_q == RPT_W'(1));
   always_comb begin
      if (rpt_hit)      pc_next = rpt_last ? pc_now : rb_q;
      else if (chg_any) pc_next = pc_now;
      else              pc_next = pc + PC_W'(1);
   end

   assign fetch_req = (state == ST_FETCH);
   assign halted    = (state == ST_HALT);
   assign exe_go    = (state == ST_ISS1) || (state == ST_ISS2);
   assign exe_long  = (state == ST_ISS1) && first_long;
   assign exe_left  = (state == ST_ISS2) ? !first_left : first_left;
   assign exe_op    = (state == ST_ISS2) ? second_op : first_op;
   assign exe_class = exe_long ? exe_op[OP_W-1 -: CLS_W] : exe_op[SHORT_W-1 -: CLS_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_HALT;
         pc         <= '0;
         word_q     <= '0;
         lt_q       <= 1'b0;
         rt_q       <= 1'b0;
         step_q     <= 1'b0;
         trap       <= 1'b0;
         exc_seen   <= 1'b0;
         r1_chg     <= 1'b0;
         r1_exc     <= 1'b0;
         r1_flag    <= 1'b0;
         chg_any    <= 1'b0;
         exc_any    <= 1'b0;
         tgt_q      <= '0;
         rpt_active <= 1'b0;
         rb_q       <= '0;
         re_q       <= '0;
         rc_q       <= '0;
      end else begin
         case (state)
            ST_HALT: begin
               if (rpt_load) begin
                  rpt_active <= (rpt_count != '0);
                  rb_q       <= rpt_begin;
                  re_q       <= rpt_end;
                  rc_q       <= rpt_count;
               end
               if (start) begin
                  pc       <= start_pc;
                  step_q   <= step;
                  trap     <= 1'b0;
                  exc_seen <= 1'b0;
                  state    <= ST_FETCH;
               end
            end
            ST_FETCH: if (insn_valid) begin
               word_q  <= insn_word;
               lt_q    <= left_test;
               rt_q    <= right_test;
               chg_any <= 1'b0;
               exc_any <= 1'b0;
               state   <= ST_ISS1;
            end
            ST_ISS1: state <= ST_WAIT1;
            ST_WAIT1: if (done_valid) begin
               r1_chg  <= done_pc_chg;
               r1_exc  <= done_exc;
               r1_flag <= done_flag;
               exc_any <= done_exc;
               if (done_pc_chg) begin
                  chg_any <= 1'b1;
                  tgt_q   <= done_pc;
               end
               state <= run2 ? ST_ISS2 : ST_END;
            end
            ST_ISS2: state <= ST_WAIT2;
            ST_WAIT2: if (done_valid) begin
               if (done_exc) exc_any <= 1'b1;
               if (done_pc_chg) begin
                  chg_any <= 1'b1;
                  tgt_q   <= done_pc;
               end
               state <= ST_END;
            end
            default: begin
               pc <= pc_next;
               if (rpt_hit) begin
                  rc_q <= rc_q - RPT_W'(1);
                  if (rpt_last) rpt_active <= 1'b0;
               end
               if (exc_any) begin
                  exc_seen <= 1'b1;
                  state    <= ST_HALT;
               end else if (step_q) begin
                  trap  <= 1'b1;
                  state <= ST_HALT;
               end else begin
                  state <= ST_FETCH;
               end
            end
         endcase
      end
   end

   // Event counters
   logic [CNT_NUM-1:0]       inc;
   logic [CNT_NUM*CNT_W-1:0] cnt_flat;
   logic                     at_end;
   assign at_end = (state == ST_END);
   always_comb begin
      inc           = '0;
      inc[CI_CYC]   = at_end;
      inc[CI_LONG]  = at_end && (fmt == FMT_LONG);
      inc[CI_PAR]   = at_end && (fmt == FMT_PAR);
      inc[CI_LR]    = at_end && (fmt == FMT_LR);
      inc[CI_RL]    = at_end && (fmt == FMT_RL);
      inc[CI_TRUE]  = at_end && (rule == NEXT_COND) && r1_flag;
      inc[CI_FALSE] = at_end && (rule == NEXT_COND) && !r1_flag;
      inc[CI_JSKIP] = at_end && (rule == NEXT_SEQ) && r1_chg && !r1_exc;
   end

   issue_counters #(.NUM(CNT_NUM), .W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc), .count_flat(cnt_flat)
   );

   assign cnt_cycles = cnt_flat[CI_CYC*CNT_W +: CNT_W];
   assign cnt_long   = cnt_flat[CI_LONG*CNT_W +: CNT_W];
   assign cnt_par    = cnt_flat[CI_PAR*CNT_W +: CNT_W];
   assign cnt_lr     = cnt_flat[CI_LR*CNT_W +: CNT_W];
   assign cnt_rl     = cnt_flat[CI_RL*CNT_W +: CNT_W];
   assign cnt_true   = cnt_flat[CI_TRUE*CNT_W +: CNT_W];
   assign cnt_false  = cnt_flat[CI_FALSE*CNT_W +: CNT_W];
   assign cnt_jskip  = cnt_flat[CI_JSKIP*CNT_W +: CNT_W];
endmodule

// File: rtl/issue_seq_chk.sv
module issue_seq_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             exe_go,
   input logic             fetch_req,
   input logic             halted,
   input logic             trap,
   input logic             exc_seen,
   input logic [CNT_W-1:0] cnt_cycles,
   input logic [CNT_W-1:0] cnt_jskip
);
   a_r13_go_pulse: assert property (@(posedge clk) disable iff (rst)
      exe_go |=> !exe_go);

   a_r13_go_vs_fetch: assert property (@(posedge clk) disable iff (rst)
      !(exe_go && fetch_req));

   a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!exe_go && !fetch_req));

   a_r11_trap_halted: assert property (@(posedge clk) disable iff (rst)
      trap |-> (halted && !exc_seen));

   a_r12_cyc_no_wrap: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (cnt_cycles >= $past(cnt_cycles)));

   a_r12_jskip_no_wrap: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (cnt_jskip >= $past(cnt_jskip)));

   a_r9_cyc_one_step: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((cnt_cycles - $past(cnt_cycles)) <= CNT_W'(1)));
endmodule

bind issue_seq issue_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .exe_go(exe_go), .fetch_req(fetch_req),
   .halted(halted), .trap(trap), .exc_seen(exc_seen),
   .cnt_cycles(cnt_cycles), .cnt_jskip(cnt_jskip)
);

// File: tb/issue_seq_test.sv
module issue_seq_test;
   localparam int PC_W  = 8;
   localparam int RPT_W = 4;
   localparam int CNT_W = 3;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic              start = 0, step = 0, rpt_load = 0;
   logic [PC_W-1:0]   start_pc = '0, rpt_begin = '0, rpt_end = '0;
   logic [RPT_W-1:0]  rpt_count = '0;
   logic              fetch_req, insn_valid = 0, left_test = 0, right_test = 0;
   logic [31:0]       insn_word = '0;
   logic              exe_go, exe_long, exe_left;
   logic [29:0]       exe_op;
   logic [5:0]        exe_class;
   logic              done_valid = 0, done_pc_chg = 0, done_exc = 0, done_flag = 0;
   logic [PC_W-1:0]   done_pc = '0;
   logic [PC_W-1:0]   pc;
   logic              halted, trap, exc_seen, rpt_active;
   logic [CNT_W-1:0]  c_cyc, c_long, c_par, c_lr, c_rl, c_true, c_false, c_jskip;

   issue_seq #(.PC_W(PC_W), .RPT_W(RPT_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst(rst), .start(start), .step(step), .start_pc(start_pc),
      .rpt_load(rpt_load), .rpt_begin(rpt_begin), .rpt_end(rpt_end), .rpt_count(rpt_count),
      .fetch_req(fetch_req), .insn_valid(insn_valid), .insn_word(insn_word),
      .left_test(left_test), .right_test(right_test),
      .exe_go(exe_go), .exe_long(exe_long), .exe_left(exe_left), .exe_op(exe_op),
      .exe_class(exe_class), .done_valid(done_valid), .done_pc_chg(done_pc_chg),
      .done_pc(done_pc), .done_exc(done_exc), .done_flag(done_flag),
      .pc(pc), .halted(halted), .trap(trap), .exc_seen(exc_seen), .rpt_active(rpt_active),
      .cnt_cycles(c_cyc), .cnt_long(c_long), .cnt_par(c_par), .cnt_lr(c_lr),
      .cnt_rl(c_rl), .cnt_true(c_true), .cnt_false(c_false), .cnt_jskip(c_jskip)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Reference state
   int m_pc = 0;
   int m_cnt[8];
   bit m_halt = 1, m_trap = 0, m_exc = 0, m_step = 0;
   bit m_rpt = 0;
   int m_rb = 0, m_re = 0, m_rc = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int dut_cnt(input int i);
      case (i)
         0: return int'(c_cyc);
         1: return int'(c_long);
         2: return int'(c_par);
         3: return int'(c_lr);
         4: return int'(c_rl);
         5: return int'(c_true);
         6: return int'(c_false);
         default: return int'(c_jskip);
      endcase
   endfunction

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   task automatic compare_state(input string req);
      chk(int'(pc) == (m_pc & 8'hFF), req, "pc", int'(pc), m_pc & 8'hFF);
      chk(halted == m_halt, req, "halted", int'(halted), int'(m_halt));
      chk(trap == m_trap, "R11", "trap", int'(trap), int'(m_trap));
      chk(exc_seen == m_exc, "R10", "exc_seen", int'(exc_seen), int'(m_exc));
      chk(rpt_active == m_rpt, "R7", "rpt_active", int'(rpt_active), int'(m_rpt));
      for (int i = 0; i < 8; i++)
         chk(dut_cnt(i) == sat(m_cnt[i]), (i == 0) ? "R12" : req, $sformatf("counter %0d", i),
             dut_cnt(i), sat(m_cnt[i]));
   endtask

   task automatic do_start(input int spc, input bit st, input bit ld, input int rb, input int re, input int rc);
      @(negedge clk);
      start = 1; start_pc = PC_W'(spc); step = st;
      rpt_load = ld; rpt_begin = PC_W'(rb); rpt_end = PC_W'(re); rpt_count = RPT_W'(rc);
      @(negedge clk);
      start = 0; rpt_load = 0;
      m_pc = spc; m_step = st; m_trap = 0; m_exc = 0; m_halt = 0;
      if (ld) begin
         m_rpt = (rc != 0); m_rb = rb; m_re = re; m_rc = rc;
      end
   endtask

   task automatic issue(input bit left, input logic [29:0] op, input bit lng,
                        input bit c, input int p, input bit e, input bit f, input string req);
      bit seen = 0;
      int exp_cls;
      for (int i = 0; i < 60 && !seen; i++) begin
         if (exe_go) seen = 1; else @(negedge clk);
      end
      chk(seen, req, "exe_go seen", int'(seen), 1);
      if (!seen) return;
      exp_cls = lng ? int'(op[29:24]) : int'(op[14:9]);
      chk(exe_long == lng, "R1", "exe_long", int'(exe_long), int'(lng));
      if (!lng) chk(exe_left == left, req, "exe_left", int'(exe_left), int'(left));
      chk(exe_op == op, "R2", "exe_op", int'(exe_op), int'(op));
      chk(int'(exe_class) == exp_cls, "R2", "exe_class", int'(exe_class), exp_cls);
      @(negedge clk);
      done_valid = 1; done_pc_chg = c; done_pc = PC_W'(p); done_exc = e; done_flag = f;
      @(negedge clk);
      done_valid = 0; done_pc_chg = 0; done_exc = 0; done_flag = 0;
   endtask

   task automatic do_word(input logic [31:0] w, input bit lt, input bit rt,
                          input bit c1, input int p1, input bit e1, input bit f1,
                          input bit c2, input int p2, input bit e2, input bit f2,
                          input string req);
      logic [1:0]  fm;
      logic [29:0] lop, rop, op1, op2;
      bit          left1, lng, run2, chg, ex, seen, extra;
      int          rule, npc, pnow;
      fm  = w[31:30];
      lop = {15'd0, w[29:15]};
      rop = {15'd0, w[14:0]};
      lng = (fm == 2'b11);
      rule = 0; left1 = 1; op1 = lop; op2 = rop;
      if (lng) op1 = w[29:0];
      else if (fm == 2'b01) rule = 1;
      else if (fm == 2'b10) begin rule = 1; left1 = 0; op1 = rop; op2 = lop; end
      else begin
         rule = (lt || rt) ? 2 : 3;
         if (!lt && rt) begin left1 = 0; op1 = rop; op2 = lop; end
      end
      seen = 0;
      for (int i = 0; i < 60 && !seen; i++) begin
         if (fetch_req) seen = 1; else @(negedge clk);
      end
      chk(seen, "R8", "fetch_req", int'(seen), 1);
      chk(int'(pc) == (m_pc & 8'hFF), "R8", "fetch pc", int'(pc), m_pc & 8'hFF);
      insn_valid = 1; insn_word = w; left_test = lt; right_test = rt;
      @(negedge clk);
      insn_valid = 0; left_test = 0; right_test = 0;
      issue(left1, op1, lng, c1, p1, e1, f1, req);
      case (rule)
         1: run2 = !c1 && !e1;
         2: run2 = f1 && !e1;
         3: run2 = !e1;
         default: run2 = 0;
      endcase
      if (run2) issue(!left1, op2, 1'b0, c2, p2, e2, f2, req);
      extra = 0;
      for (int i = 0; i < 60; i++) begin
         if (exe_go) extra = 1;
         if (fetch_req || halted) break;
         @(negedge clk);
      end
      chk(!extra, req, "no further issue", int'(extra), 0);
      // Reference update
      chg = c1 || (run2 && c2);
      npc = (run2 && c2) ? p2 : p1;
      ex  = e1 || (run2 && e2);
      pnow = chg ? npc : m_pc;
      if (m_rpt && ((pnow & 8'hFF) == m_re)) begin
         m_rc--;
         if (m_rc == 0) begin m_rpt = 0; m_pc = pnow; end
         else m_pc = m_rb;
      end else if (chg) m_pc = pnow;
      else m_pc = (m_pc + 1) & 8'hFF;
      m_cnt[0]++;
      if (fm == 2'b11) m_cnt[1]++;
      if (fm == 2'b00) m_cnt[2]++;
      if (fm == 2'b01) m_cnt[3]++;
      if (fm == 2'b10) m_cnt[4]++;
      if (rule == 2) begin if (f1) m_cnt[5]++; else m_cnt[6]++; end
      if (rule == 1 && c1 && !e1) m_cnt[7]++;
      if (ex) begin m_halt = 1; m_exc = 1; end
      else if (m_step) begin m_halt = 1; m_trap = 1; end
      compare_state(req);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R12 reset state
      compare_state("R12");
      chk(!exe_go && !fetch_req, "R10", "idle after reset", int'({exe_go, fetch_req}), 0);

      do_start(8'h10, 0, 0, 0, 0, 0);
      // R1 long word
      do_word({2'b11, 30'h2ABCDEF1}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      // R3 left first
      do_word({2'b01, 15'h1234, 15'h0567}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
      // R3 right first
      do_word({2'b10, 15'h7A00, 15'h05FF}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
      // R4 jump in first slot drops second
      do_word({2'b10, 15'h0101, 15'h0202}, 0, 0, 1, 8'h40, 0, 0, 0, 0, 0, 0, "R4");
      // R6 left branch does not drop right; R8 target taken
      do_word({2'b00, 15'h0303, 15'h0404}, 0, 0, 1, 8'h50, 0, 0, 0, 0, 0, 0, "R6");
      // R8 second-slot target wins
      do_word({2'b01, 15'h0111, 15'h0222}, 0, 0, 0, 0, 0, 0, 1, 8'h60, 0, 0, "R8");
      // R5 right test true
      do_word({2'b00, 15'h1111, 15'h2222}, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
      // R5 left test false
      do_word({2'b00, 15'h3333, 15'h4444}, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
      // R5 both flagged: left first, true
      do_word({2'b00, 15'h5555, 15'h6666}, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
      // R4 exception in first seq slot, R10 halt
      do_word({2'b01, 15'h0aaa, 15'h0bbb}, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
      repeat (5) begin
         @(negedge clk);
         chk(!fetch_req && !exe_go && halted, "R10", "held after exception",
             int'({halted, fetch_req, exe_go}), 4);
      end

      // R7 repeat window 0x20..0x21, count 2
      do_start(8'h20, 0, 1, 8'h20, 8'h21, 2);
      do_word({2'b11, 30'h00000001}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      do_word({2'b11, 30'h00000002}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      do_word({2'b11, 30'h00000003}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      do_word({2'b11, 30'h00000004}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      do_word({2'b11, 30'h00000005}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
      // R6 left exception drops right
      do_word({2'b00, 15'h0c0c, 15'h0d0d}, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6");

      // R11 single step, plus a zero-count load leaves repeat off (R7)
      do_start(8'h30, 1, 1, 8'h30, 8'h31, 0);
      do_word({2'b10, 15'h0e0e, 15'h0f0f}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
      repeat (3) begin
         @(negedge clk);
         chk(halted && trap && !fetch_req, "R11", "held after step",
             int'({halted, trap, fetch_req}), 6);
      end

      // R12 reset clears counters
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
      m_pc = 0; m_halt = 1; m_trap = 0; m_exc = 0; m_rpt = 0;
      @(negedge clk);
      compare_state("R12");

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule